// File: doc/BRIEF.md
# Triggered Pulse Sequencer with Holdoff

The block rests in an idle state until it samples its trigger input high on a clock edge. It then drives a strobe high for a fixed number of clock cycles. After that it holds the strobe low for a second fixed number of cycles, the holdoff, and only then returns to idle, where it can accept a new trigger. Both lengths are parameters, and every interval is counted in cycles of a single clock.

The strobe and a busy flag are decoded from a registered three-state controller (idle, on, rest). One shared counter times both timed phases and is cleared on every change of state. A trigger seen while the sequence is running is dropped and is not stored. This gives a guaranteed low recovery interval between strobes, which a retriggerable one-shot does not provide.

Top module: `pulse_sequencer`

## Requirements
- R1: While idle and with the trigger low, strobe and busy stay 0.
- R2: A trigger sampled high while idle sets the strobe to 1 after that same clock edge. There is no combinational path from trigger to strobe.
- R3: The strobe stays high for exactly HIGH_CYCLES consecutive cycles (HIGH_CYCLES >= 1) and then goes low.
- R4: After the strobe falls, busy stays high with the strobe low for exactly OFF_CYCLES cycles. Busy then drops to 0.
- R5: Busy is 1 in every cycle in which the strobe is 1 or the holdoff is running, and 0 only when idle.
- R6: A trigger that is high during the strobe phase or the holdoff phase has no effect. It neither lengthens the current sequence nor starts a later one.
- R7: On the clock edge where the holdoff ends, the block is not yet idle, so a trigger sampled at that edge is ignored. A trigger still high at the next edge starts a new strobe after that edge.
- R8: The active-low reset rst_n forces idle at once: strobe 0, busy 0, counter cleared. A trigger after reset yields a full HIGH_CYCLES strobe.
- R9: With OFF_CYCLES = 0, busy falls together with the strobe, and a trigger at the next edge is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; all timing is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset to idle |
| trig | input | 1 | Synchronous start request, sampled on rising clock edges |
| strobe | output | 1 | High only while the on phase runs |
| busy | output | 1 | High in the on and holdoff phases |

## Verification
The delicate coincidence is a trigger that is high on the edge where the holdoff expires. That edge both ends the sequence and samples the trigger. The bench holds the trigger high through a whole sequence and checks two things at the ports. The edge that ends the holdoff must leave the block idle, with strobe and busy both low for one cycle. The following edge must then start a new, full-width strobe. The zero-holdoff variant is driven the same way, with the strobe end and the re-arm edge adjacent.

// File: rtl/pulse_sequencer.sv
module pulse_sequencer #(
  parameter int HIGH_CYCLES = 5,
  parameter int OFF_CYCLES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic strobe,
  output logic busy
);
  localparam int LONGEST = (HIGH_CYCLES > OFF_CYCLES) ? HIGH_CYCLES : OFF_CYCLES;
  localparam int CW      = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam int ON_LAST   = (HIGH_CYCLES > 0) ? HIGH_CYCLES - 1 : 0;
  localparam int REST_LAST = (OFF_CYCLES  > 0) ? OFF_CYCLES  - 1 : 0;

  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_REST} st_t;

  st_t           state;
  logic [CW-1:0] cnt;

  wire on_done   = (cnt == CW'(ON_LAST));
  wire rest_done = (cnt == CW'(REST_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (trig) state <= ST_ON;
        end
        ST_ON: begin
          if (on_done) begin
            cnt   <= '0;
            state <= (OFF_CYCLES > 0) ? ST_REST : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REST: begin
          if (rest_done) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          cnt   <= '0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign strobe = (state == ST_ON);
  assign busy   = (state != ST_IDLE);
endmodule

// File: rtl/pulse_sequencer_chk.sv
module pulse_sequencer_chk #(
  parameter int HIGH_CYCLES = 5,
  parameter int OFF_CYCLES  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic strobe,
  input logic busy
);
  int run_q;
  int rest_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 0;
      rest_q <= 0;
    end else begin
      run_q  <= strobe ? run_q + 1 : 0;
      rest_q <= (busy && !strobe) ? rest_q + 1 : 0;
    end
  end

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && trig) |=> strobe);
  a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trig) |=> (!busy && !strobe));
  a_r5_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> busy);
  a_r3_width_max: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (run_q < HIGH_CYCLES));
  a_r3_width_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (run_q == HIGH_CYCLES));
  a_r4_rest_max: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strobe) |-> (rest_q < OFF_CYCLES));
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(!busy) && $past(trig)));
  a_r9_zero_rest: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strobe) && OFF_CYCLES == 0) |-> !busy);
endmodule

bind pulse_sequencer pulse_sequencer_chk #(
  .HIGH_CYCLES(HIGH_CYCLES),
  .OFF_CYCLES (OFF_CYCLES)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .trig  (trig),
  .strobe(strobe),
  .busy  (busy)
);

// File: tb/pulse_sequencer_tb.sv
`timescale 1ns/1ps
module pulse_sequencer_tb;
  localparam int H  = 5;
  localparam int O  = 3;
  localparam int HZ = 2;

  logic clk = 0;
  logic rst_n = 0;
  logic trig = 0, trig_z = 0;
  logic strobe, busy, strobe_z, busy_z;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pulse_sequencer #(.HIGH_CYCLES(H), .OFF_CYCLES(O)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .strobe(strobe), .busy(busy));
  pulse_sequencer #(.HIGH_CYCLES(HZ), .OFF_CYCLES(0)) u_dut_z (
    .clk(clk), .rst_n(rst_n), .trig(trig_z), .strobe(strobe_z), .busy(busy_z));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R8 reset strobe", strobe, 1'b0);
    chk("R8 reset busy", busy, 1'b0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 8; i++) begin
      tick();
      chk("R1 idle strobe", strobe, 1'b0);
      chk("R1 idle busy", busy, 1'b0);
    end
  endtask

  task automatic t_basic();
    trig = 1; tick(); trig = 0;
    for (int i = 0; i <= H + O + 1; i++) begin
      chk("R2 R3 strobe trace", strobe, i < H);
      chk("R4 R5 busy trace", busy, i < H + O);
      tick();
    end
  endtask

  task automatic t_held();
    trig = 1; tick();
    for (int i = 0; i <= H + O + 1; i++) begin
      if (i < H + O) chk("R6 held trigger strobe", strobe, i < H);
      else if (i == H + O) begin
        chk("R7 idle gap strobe", strobe, 1'b0);
        chk("R7 idle gap busy", busy, 1'b0);
      end else chk("R7 restart strobe", strobe, 1'b1);
      tick();
    end
    trig = 0;
    repeat (H + O + 2) tick();
    chk("R1 back to idle", busy, 1'b0);
  endtask

  task automatic t_midpulse();
    trig = 1; tick(); trig = 0;
    for (int i = 0; i <= H + O + 3; i++) begin
      if (i == 2 || i == H + 1) trig = 1; else trig = 0;
      chk("R6 mid trigger strobe", strobe, i < H);
      chk("R6 mid trigger busy", busy, i < H + O);
      tick();
    end
    trig = 0;
    tick();
  endtask

  task automatic t_reset_mid();
    trig = 1; tick(); trig = 0;
    tick(); tick();
    rst_n = 0; #2;
    chk("R8 async reset strobe", strobe, 1'b0);
    chk("R8 async reset busy", busy, 1'b0);
    tick(); rst_n = 1; tick();
    trig = 1; tick(); trig = 0;
    for (int i = 0; i <= H; i++) begin
      chk("R8 full width after reset", strobe, i < H);
      tick();
    end
    repeat (O + 2) tick();
  endtask

  task automatic t_zero_rest();
    trig_z = 1; tick();
    for (int i = 0; i <= HZ + 1; i++) begin
      if (i < HZ) begin
        chk("R9 strobe", strobe_z, 1'b1);
        chk("R9 busy", busy_z, 1'b1);
      end else if (i == HZ) begin
        chk("R9 busy falls with strobe", busy_z, 1'b0);
        chk("R9 strobe low", strobe_z, 1'b0);
      end else chk("R9 rearm", strobe_z, 1'b1);
      tick();
    end
    trig_z = 0;
    repeat (HZ + 2) tick();
    chk("R9 idle", busy_z, 1'b0);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1;
    t_idle();
    t_basic();
    t_held();
    t_midpulse();
    t_reset_mid();
    t_zero_rest();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule